// File: doc/BRIEF.md
# Adaptive Half-Bridge Gate Sequencer

This block turns one PWM command into the two gate enables of a half-bridge power stage. It does not use a fixed delay between the two switches. Each switch waits until a sense flag reports that the opposite gate has discharged. The upper switch also waits until a minimum off interval has passed since it last turned off. That interval gives the bootstrap supply time to recharge and gives the overcurrent logic time to take its sample.

With forced-continuous mode off, the block emulates a diode. It cuts the lower switch when the zero-cross flag reports that the inductor current is about to reverse. It keeps the lower switch off until the next PWM falling edge. With forced-continuous mode on, the zero-cross flag is ignored.

A fixed number of cycles after the lower gate turns on, the block raises a one-cycle strobe for the overcurrent check on the phase node. The supervisor can force both gates off at once with a tristate request or by dropping the enable. If a discharge flag never arrives, a timeout set at a port lets the hand-off go ahead anyway.

Top module: `adaptive_gate_ctl`

## Requirements
- R1: `hi_gate_en` and `lo_gate_en` are never high in the same cycle.
- R2: PWM rises while the upper switch has been off for at least `MIN_OFF_CYC` cycles. The lower gate drops on the next clock edge. The upper gate turns on at the first clock edge, after one full cycle of dead time, at which `lo_gate_low` is high. With `lo_gate_low` arriving d cycles after the rise, `hi_gate_en` is first seen max(d,1)+1 cycles after the rise.
- R3: PWM falls. The upper gate drops on the next clock edge. The lower gate turns on at the first clock edge, after one full cycle of dead time, at which `hi_gate_low` is high. The delay follows the same max(d,1)+1 rule.
- R4: A discharge flag may stay low. In that case the waiting gate turns on after `dis_timeout`+1 cycles of dead time. This caps both R2 and R3 delays at `dis_timeout`+2 cycles from the PWM edge.
- R5: While the lower gate is on, `force_ccm` is 0 and `zero_cross` is 1. The lower gate then turns off on the next clock edge.
- R6: After a zero-cross cut, the lower gate stays off, even after `zero_cross` returns to 0, until PWM has risen and fallen again.
- R7: With `force_ccm` = 1, `zero_cross` has no effect. The lower gate stays on for as long as PWM is low.
- R8: Once the upper gate turns off, it cannot turn on again for `MIN_OFF_CYC`+1 cycles, even if PWM rises and `lo_gate_low` is high.
- R9: `oc_sample` is a one-cycle pulse. It is seen exactly `OC_DLY_CYC` cycles after `lo_gate_en` is first seen high. It occurs only while the lower gate is on, and it does not occur if the lower gate turns off sooner.
- R10: `tri_req` = 1 forces both gate enables and `oc_sample` low in the same cycle, through logic with no register. After release, both gates stay off until PWM is high. The upper gate is then seen on 2 cycles after release, provided its flag and minimum off time allow it.
- R11: During reset and while `drv_en` = 0, all outputs are low. `drv_en` = 0 forces the gates off in the same cycle. After reset the lower gate stays off until the first PWM cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drv_en | input | 1 | Driver enable from the supervisor |
| tri_req | input | 1 | Tristate request: both gates off at once |
| pwm | input | 1 | PWM command (high = upper switch on) |
| force_ccm | input | 1 | 1 = forced continuous, 0 = diode emulation |
| zero_cross | input | 1 | Inductor current about to reverse |
| lo_gate_low | input | 1 | Lower gate sensed discharged |
| hi_gate_low | input | 1 | Upper gate-to-phase sensed discharged |
| dis_timeout | input | TO_W | Cycles to wait for a missing discharge flag |
| hi_gate_en | output | 1 | Upper switch gate enable |
| lo_gate_en | output | 1 | Lower switch gate enable |
| oc_sample | output | 1 | Strobe for the overcurrent sample of the phase node |

## Verification
The bound checker checks the following on every clock:
- the two gates are never high together;
- each gate rises only after a cycle in which the other gate was off;
- a tristate request holds every output low;
- the overcurrent strobe is a single pulse inside a lower-gate interval;
- a zero-cross cut happens in diode emulation;
- the lower gate is held in forced-continuous mode.

Other behaviours need the bench's scenarios because they depend on counted time:
- the exact hand-off delays for each flag arrival;
- the timeout cap;
- the minimum off interval;
- the strobe offset;
- the hold-off until the next PWM fall;
- the return from tristate or disable.

// File: rtl/gd_pkg.sv
package gd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WAIT_HI = 3'd1,
    ST_HI      = 3'd2,
    ST_WAIT_LO = 3'd3,
    ST_LO      = 3'd4,
    ST_LO_HOLD = 3'd5
  } gd_state_e;

  // A hand-off may proceed when the opposite gate is sensed low or the wait ran out.
  function automatic logic f_path_clear(input logic sensed, input logic expired);
    return sensed | expired;
  endfunction

  // Saturating count has reached a limit.
  function automatic logic f_limit_hit(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt >= lim;
  endfunction

  // The lower switch is cut on zero crossing only in diode emulation.
  function automatic logic f_zc_cut(input logic ccm, input logic zc);
    return !ccm && zc;
  endfunction

  // Both gates are inhibited by tristate or by a dropped enable.
  function automatic logic f_inhibit(input logic tri_q, input logic en);
    return tri_q | ~en;
  endfunction

endpackage

// File: rtl/gd_span_counter.sv
module gd_span_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CMAX = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (run && cnt != CMAX) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/gd_holdoff.sv
module gd_holdoff #(
  parameter int unsigned LOAD = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);

  localparam int unsigned W = $clog2(LOAD + 2);

  generate
    if (LOAD == 0) begin : g_none
      assign done = 1'b1;
    end else begin : g_count
      logic [W-1:0] remain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           remain <= '0;
        else if (load)        remain <= W'(LOAD);
        else if (remain != 0) remain <= remain - 1'b1;
      end
      assign done = (remain == '0);
    end
  endgenerate

endmodule

// File: rtl/gd_seq.sv
module gd_seq
  import gd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inhibit,
  input  logic      pwm,
  input  logic      force_ccm,
  input  logic      zero_cross,
  input  logic      lo_clear,
  input  logic      hi_clear,
  input  logic      minoff_done,
  output gd_state_e st,
  output gd_state_e st_nxt
);

  always_comb begin
    st_nxt = st;
    if (inhibit) begin
      st_nxt = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE:    if (pwm) st_nxt = ST_WAIT_HI;
        ST_WAIT_HI: begin
          if (!pwm)                           st_nxt = ST_WAIT_LO;
          else if (lo_clear && minoff_done)   st_nxt = ST_HI;
        end
        ST_HI:      if (!pwm) st_nxt = ST_WAIT_LO;
        ST_WAIT_LO: begin
          if (pwm)           st_nxt = ST_WAIT_HI;
          else if (hi_clear) st_nxt = ST_LO;
        end
        ST_LO: begin
          if (pwm)                                st_nxt = ST_WAIT_HI;
          else if (f_zc_cut(force_ccm, zero_cross)) st_nxt = ST_LO_HOLD;
        end
        ST_LO_HOLD: if (pwm) st_nxt = ST_WAIT_HI;
        default:    st_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

endmodule

// File: rtl/adaptive_gate_ctl.sv
module adaptive_gate_ctl
  import gd_pkg::*;
#(
  parameter int unsigned TO_W        = 8,
  parameter int unsigned MIN_OFF_CYC = 50,
  parameter int unsigned OC_DLY_CYC  = 27
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            drv_en,
  input  logic            tri_req,
  input  logic            pwm,
  input  logic            force_ccm,
  input  logic            zero_cross,
  input  logic            lo_gate_low,
  input  logic            hi_gate_low,
  input  logic [TO_W-1:0] dis_timeout,
  output logic            hi_gate_en,
  output logic            lo_gate_en,
  output logic            oc_sample
);

  localparam int unsigned WAIT_W = TO_W + 1;
  localparam int unsigned OC_W   = $clog2(OC_DLY_CYC + 1) + 1;

  gd_state_e          st, st_nxt;
  logic               inhibit;
  logic               state_moves;
  logic               in_wait;
  logic               wait_expired;
  logic               lo_clear, hi_clear;
  logic               upper_leaving;
  logic               minoff_done;
  logic [WAIT_W-1:0]  wait_cnt;
  logic [OC_W-1:0]    lo_cnt;
  logic               lo_stays;
  logic               strobe_hit;

  assign inhibit      = f_inhibit(tri_req, drv_en);
  assign state_moves  = (st_nxt != st);
  assign in_wait      = (st == ST_WAIT_HI) || (st == ST_WAIT_LO);
  assign wait_expired = in_wait && f_limit_hit(32'(wait_cnt), 32'(dis_timeout));
  assign lo_clear     = f_path_clear(lo_gate_low, wait_expired);
  assign hi_clear     = f_path_clear(hi_gate_low, wait_expired);
  assign upper_leaving = (st == ST_HI) && (st_nxt != ST_HI);
  assign lo_stays     = (st_nxt == ST_LO);

  gd_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .inhibit     (inhibit),
    .pwm         (pwm),
    .force_ccm   (force_ccm),
    .zero_cross  (zero_cross),
    .lo_clear    (lo_clear),
    .hi_clear    (hi_clear),
    .minoff_done (minoff_done),
    .st          (st),
    .st_nxt      (st_nxt)
  );

  gd_span_counter #(.W(WAIT_W)) u_wait_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_moves),
    .run   (in_wait),
    .cnt   (wait_cnt)
  );

  gd_span_counter #(.W(OC_W)) u_lo_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!lo_stays),
    .run   (st == ST_LO),
    .cnt   (lo_cnt)
  );

  gd_holdoff #(.LOAD(MIN_OFF_CYC)) u_minoff (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (upper_leaving),
    .done  (minoff_done)
  );

  assign strobe_hit = (st == ST_LO) && (lo_cnt == OC_W'(OC_DLY_CYC));

  assign hi_gate_en = (st == ST_HI) && !inhibit;
  assign lo_gate_en = (st == ST_LO) && !inhibit;
  assign oc_sample  = strobe_hit && !inhibit;

endmodule

// File: rtl/gd_checker.sv
module gd_checker (
  input logic clk,
  input logic rst_n,
  input logic drv_en,
  input logic tri_req,
  input logic pwm,
  input logic force_ccm,
  input logic zero_cross,
  input logic hi_gate_en,
  input logic lo_gate_en,
  input logic oc_sample
);

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_gate_en && lo_gate_en));

  a_r2_hi_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_gate_en) |-> !$past(lo_gate_en));

  a_r3_lo_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_gate_en) |-> !$past(hi_gate_en));

  a_r5_zc_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_gate_en && !force_ccm && zero_cross) |=> !lo_gate_en);

  a_r7_ccm_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_gate_en && force_ccm && !pwm) |=> (lo_gate_en || tri_req || !drv_en));

  a_r9_strobe_in_lo: assert property (@(posedge clk) disable iff (!rst_n)
    oc_sample |-> lo_gate_en);

  a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    oc_sample |=> !oc_sample);

  a_r10_tristate_off: assert property (@(posedge clk) disable iff (!rst_n)
    tri_req |-> (!hi_gate_en && !lo_gate_en && !oc_sample));

endmodule

bind adaptive_gate_ctl gd_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .drv_en     (drv_en),
  .tri_req    (tri_req),
  .pwm        (pwm),
  .force_ccm  (force_ccm),
  .zero_cross (zero_cross),
  .hi_gate_en (hi_gate_en),
  .lo_gate_en (lo_gate_en),
  .oc_sample  (oc_sample)
);

// File: tb/tb_adaptive_gate_ctl.sv
module tb_adaptive_gate_ctl;

  localparam int TO_W = 8;
  localparam int MOFF = 12;
  localparam int OCD  = 5;
  localparam int TLIM = 6;

  // {force_ccm, inject_zc, lower-flag delay[4:0], upper-flag delay[4:0]}
  localparam logic [11:0] VEC [6] = '{
    {1'b1, 1'b0, 5'd0,  5'd0},
    {1'b1, 1'b1, 5'd3,  5'd2},
    {1'b0, 1'b0, 5'd1,  5'd5},
    {1'b0, 1'b1, 5'd20, 5'd0},
    {1'b0, 1'b1, 5'd2,  5'd20},
    {1'b1, 1'b0, 5'd6,  5'd7}
  };

  logic clk = 0, rst_n = 0, drv_en = 0, tri_req = 0, pwm = 0;
  logic force_ccm = 0, zero_cross = 0, lo_gate_low = 0, hi_gate_low = 0;
  logic [TO_W-1:0] dis_timeout = TO_W'(TLIM);
  wire hi_gate_en, lo_gate_en, oc_sample;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  adaptive_gate_ctl #(.TO_W(TO_W), .MIN_OFF_CYC(MOFF), .OC_DLY_CYC(OCD)) dut (
    .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .tri_req(tri_req), .pwm(pwm),
    .force_ccm(force_ccm), .zero_cross(zero_cross), .lo_gate_low(lo_gate_low),
    .hi_gate_low(hi_gate_low), .dis_timeout(dis_timeout),
    .hi_gate_en(hi_gate_en), .lo_gate_en(lo_gate_en), .oc_sample(oc_sample)
  );

  // Hand-off delay from a PWM edge to the gate being seen on.
  function automatic int exp_gap(input int del);
    int d;
    d = (del < 1) ? 1 : del;
    if (d > TLIM + 1) d = TLIM + 1;
    return d + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rise_meas(input int ldel, output int c);
    pwm = 1; hi_gate_low = 0; lo_gate_low = (ldel == 0); c = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      c++;
      chk(!(hi_gate_en && lo_gate_en), "R1", 1, 0);
      if (hi_gate_en) break;
      if (c >= ldel) lo_gate_low = 1;
    end
  endtask

  task automatic fall_meas(input int hdel, output int c);
    pwm = 0; lo_gate_low = 0; hi_gate_low = (hdel == 0); c = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      c++;
      chk(!(hi_gate_en && lo_gate_en), "R1", 1, 0);
      if (lo_gate_en) break;
      if (c >= hdel) hi_gate_low = 1;
    end
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    chk(!hi_gate_en && !lo_gate_en && !oc_sample, "R11", int'(hi_gate_en | lo_gate_en | oc_sample), 0);
    rst_n = 1; drv_en = 1;
    repeat (4) @(negedge clk);
    chk(!hi_gate_en && !lo_gate_en, "R11", int'(lo_gate_en), 0);

    for (int v = 0; v < 6; v++) begin
      logic f, z;
      int l, h;
      f = VEC[v][11]; z = VEC[v][10]; l = int'(VEC[v][9:5]); h = int'(VEC[v][4:0]);
      force_ccm = f;
      rise_meas(l, c);
      chk(c == exp_gap(l), (l > TLIM) ? "R4" : "R2", c, exp_gap(l));
      repeat (10) @(negedge clk);
      chk(hi_gate_en && !lo_gate_en, "R2", int'(hi_gate_en), 1);
      fall_meas(h, c);
      chk(c == exp_gap(h), (h > TLIM) ? "R4" : "R3", c, exp_gap(h));
      for (int j = 1; j <= 20; j++) begin
        bit exp_lo;
        @(negedge clk);
        exp_lo = !(z && !f && j >= 9);
        chk(lo_gate_en == exp_lo,
            !z ? "R3" : (f ? "R7" : ((j == 9) ? "R5" : "R6")), int'(lo_gate_en), int'(exp_lo));
        chk(oc_sample == (j == OCD), "R9", int'(oc_sample), int'(j == OCD));
        if (z && j == 8) zero_cross = 1;
        if (j == 9) zero_cross = 0;
      end
    end

    // R8: minimum off interval of the upper switch
    rise_meas(0, c);
    chk(c == 2, "R2", c, 2);
    repeat (5) @(negedge clk);
    pwm = 0; hi_gate_low = 1; lo_gate_low = 0;
    @(negedge clk);
    chk(!hi_gate_en, "R8", int'(hi_gate_en), 0);
    c = 0;
    for (int i = 1; i < 64; i++) begin
      @(negedge clk);
      if (hi_gate_en) begin c = i; break; end
      if (i == 2) begin pwm = 1; lo_gate_low = 1; end
    end
    chk(c == MOFF + 1, "R8", c, MOFF + 1);

    // R10: tristate while the upper gate is on
    tri_req = 1;
    #1;
    chk(!hi_gate_en && !lo_gate_en, "R10", int'(hi_gate_en), 0);
    repeat (20) @(negedge clk);
    chk(!hi_gate_en && !lo_gate_en && !oc_sample, "R10", int'(hi_gate_en | lo_gate_en), 0);
    tri_req = 0;
    @(negedge clk);
    chk(!hi_gate_en, "R10", int'(hi_gate_en), 0);
    @(negedge clk);
    chk(hi_gate_en, "R10", int'(hi_gate_en), 1);

    // R10: release with PWM low keeps the lower gate off
    tri_req = 1; pwm = 0; hi_gate_low = 1;
    repeat (5) @(negedge clk);
    tri_req = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!lo_gate_en && !hi_gate_en, "R10", int'(lo_gate_en), 0);
    end

    // R11: dropping the enable
    repeat (15) @(negedge clk);
    rise_meas(0, c);
    chk(c == 2, "R2", c, 2);
    drv_en = 0;
    #1;
    chk(!hi_gate_en && !lo_gate_en, "R11", int'(hi_gate_en), 0);
    repeat (3) @(negedge clk);
    chk(!hi_gate_en && !lo_gate_en, "R11", int'(hi_gate_en), 0);
    drv_en = 1;
    repeat (20) @(negedge clk);
    chk(hi_gate_en, "R11", int'(hi_gate_en), 1);

    // R9: lower gate cut before the strobe offset gives no strobe
    pwm = 0; hi_gate_low = 1; lo_gate_low = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      chk(!oc_sample, "R9", int'(oc_sample), 0);
      if (i == 3) begin pwm = 1; lo_gate_low = 1; end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

endmodule